// File: doc/BRIEF.md
# Acceptance Mask Register Bank

This block holds the per-buffer acceptance masks that a CAN receive path uses to decide whether an incoming identifier belongs to a given receive buffer or receive-FIFO filter element. It has 64 mask words of 32 bits each. In a mask word, a 1 bit means that identifier bit must equal the filter identifier, and a 0 bit means that bit is ignored. Software reaches the words through a plain strobe-based register port. That port is usable only while the controller is frozen. It faults when masking is switched off.

The receive matcher has its own lookup port. It names a target, which is either a regular buffer or a FIFO filter element, and an index. It also supplies the received identifier and the filter identifier. The block returns the selected mask, a valid flag and a hit flag, all in the same cycle. With the FIFO switched off, buffer n uses word n. With the FIFO switched on, FIFO filter element n (0 to 7) uses word n, and regular buffers from 8 upward keep word n. The lookup port ignores freeze and mask-enable. The mask storage has no reset and stays undefined until software writes it.

CPU accesses are classified each cycle into one of four access kinds: ACC_IDLE (no strobe), ACC_FAULT (strobe while masking disabled), ACC_BLOCKED (strobe outside freeze) and ACC_GRANTED (strobe in freeze with masking enabled). The kind is recomputed every cycle from the inputs. There is no stored state and there are no transitions other than this per-cycle decode.

Top module: `canmask_bank`

## Requirements
- R1: A write strobe while freeze_i=1 and mask_en_i=1 stores cpu_wdata_i into word cpu_addr_i at the clock edge. A later read strobe under the same conditions returns that word on cpu_rdata_o in the same cycle as the strobe.
- R2: A write strobe while freeze_i=0 and mask_en_i=1 changes no word and raises no error.
- R3: cpu_rdata_o is zero in every cycle without a granted read: no read strobe, freeze_i=0, or mask_en_i=0.
- R4: While mask_en_i=0, any read or write strobe drives cpu_err_o=1 in the same cycle, whatever freeze_i is. No word changes and cpu_rdata_o is zero.
- R5: cpu_err_o is 0 in every cycle that has no strobe or has mask_en_i=1.
- R6: With fifo_en_i=0, a lookup with lk_fifo_i=0 and any index n is valid and returns word n. A lookup with lk_fifo_i=1 is invalid.
- R7: With fifo_en_i=1, a lookup with lk_fifo_i=1 is valid only for index 0 to 7 and returns word n. A lookup with lk_fifo_i=0 is valid only for index 8 to 63 and returns word n.
- R8: An invalid lookup gives lk_valid_o=0, lk_mask_o=0 and lk_hit_o=0.
- R9: A valid lookup gives lk_hit_o=1 exactly when ((lk_rx_id_i ^ lk_filter_id_i) & lk_mask_o) is zero.
- R10: The lookup port works combinationally whatever freeze_i and mask_en_i are.
- R11: When a read and a write strobe are granted in the same cycle, the read returns the contents from before the write. The new value is visible from the next cycle.
- R12: Asserting rst_n low leaves every mask word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (control only, not storage) |
| freeze_i | input | 1 | Controller in freeze mode; CPU access allowed |
| mask_en_i | input | 1 | Masking enabled; when low every CPU access faults |
| fifo_en_i | input | 1 | Receive FIFO enabled; changes the lookup mapping |
| cpu_addr_i | input | 6 | Mask word index for CPU access |
| cpu_wdata_i | input | 32 | CPU write data |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_rd_i | input | 1 | CPU read strobe |
| cpu_rdata_o | output | 32 | CPU read data, zero unless a read is granted |
| cpu_err_o | output | 1 | Access error, same cycle as the faulting strobe |
| lk_fifo_i | input | 1 | Lookup target is a FIFO filter element (1) or a buffer (0) |
| lk_idx_i | input | 6 | Lookup buffer or filter element index |
| lk_rx_id_i | input | 32 | Received identifier |
| lk_filter_id_i | input | 32 | Filter identifier of the target |
| lk_mask_o | output | 32 | Selected mask word, zero if invalid |
| lk_valid_o | output | 1 | Lookup target exists in the current mode |
| lk_hit_o | output | 1 | Identifier accepted under the mask |

## Verification
Read data, access error and every lookup output are combinational, so they are due in the same cycle as the strobe or index that produces them. The bench drives inputs just after a falling edge and samples these outputs two nanoseconds later, before the next rising edge. A write lands at the next rising edge. The bench therefore looks for its effect only through a read issued in a later cycle, which is also how discarded and faulting writes are shown to leave the storage alone. The simultaneous read-and-write case is sampled before the edge for the old value and in the following cycle for the new one.

// File: rtl/canmask_pkg.sv
package canmask_pkg;

    // Classification of the CPU access seen in the current cycle
    typedef enum logic [1:0] {
        ACC_IDLE    = 2'd0,
        ACC_FAULT   = 2'd1,
        ACC_BLOCKED = 2'd2,
        ACC_GRANTED = 2'd3
    } acc_kind_t;

    typedef struct packed {
        logic wr_en;
        logic rd_en;
        logic err;
    } acc_ctl_t;

endpackage

// File: rtl/canmask_access.sv
module canmask_access
    import canmask_pkg::*;
(
    input  logic      freeze_i,
    input  logic      mask_en_i,
    input  logic      wr_i,
    input  logic      rd_i,
    output acc_kind_t kind_o,
    output acc_ctl_t  ctl_o
);

    acc_kind_t kind;

    // Access kind decode: fault outranks freeze gating
    always_comb begin
        if (!(wr_i || rd_i)) begin
            kind = ACC_IDLE;
        end else if (!mask_en_i) begin
            kind = ACC_FAULT;
        end else if (!freeze_i) begin
            kind = ACC_BLOCKED;
        end else begin
            kind = ACC_GRANTED;
        end
    end

    // Control outputs per access kind
    always_comb begin
        ctl_o = '0;
        unique case (kind)
            ACC_IDLE:    ctl_o = '0;
            ACC_FAULT:   ctl_o.err = 1'b1;
            ACC_BLOCKED: ctl_o = '0;
            ACC_GRANTED: begin
                ctl_o.wr_en = wr_i;
                ctl_o.rd_en = rd_i;
            end
            default:     ctl_o = '0;
        endcase
    end

    assign kind_o = kind;

endmodule

// File: rtl/canmask_store.sv
module canmask_store #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    waddr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [AW-1:0]    raddr_i,
    output logic [WIDTH-1:0] rdata_o,
    input  logic [AW-1:0]    laddr_i,
    output logic [WIDTH-1:0] ldata_o
);

    logic [WIDTH-1:0] words [DEPTH];

    // One enabled register per word; deliberately without reset
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (wr_en_i && (waddr_i == AW'(g))) begin
                words[g] <= wdata_i;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (int'(raddr_i) < DEPTH) begin
            rdata_o = words[raddr_i];
        end
    end

    always_comb begin
        ldata_o = '0;
        if (int'(laddr_i) < DEPTH) begin
            ldata_o = words[laddr_i];
        end
    end

endmodule

// File: rtl/canmask_lookup.sv
module canmask_lookup #(
    parameter int DEPTH   = 64,
    parameter int WIDTH   = 32,
    parameter int FIFO_N  = 8,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic             fifo_en_i,
    input  logic             lk_fifo_i,
    input  logic [AW-1:0]    lk_idx_i,
    input  logic [WIDTH-1:0] word_i,
    input  logic [WIDTH-1:0] rx_id_i,
    input  logic [WIDTH-1:0] flt_id_i,
    output logic [AW-1:0]    word_addr_o,
    output logic [WIDTH-1:0] mask_o,
    output logic             valid_o,
    output logic             hit_o
);

    logic in_fifo_range;

    assign in_fifo_range = (int'(lk_idx_i) < FIFO_N);
    assign word_addr_o   = lk_idx_i;

    // FIFO filter elements share the low words; buffers keep their own index
    always_comb begin
        if (fifo_en_i) begin
            valid_o = lk_fifo_i ? in_fifo_range : !in_fifo_range;
        end else begin
            valid_o = !lk_fifo_i;
        end
    end

    assign mask_o = valid_o ? word_i : '0;
    assign hit_o  = valid_o && (((rx_id_i ^ flt_id_i) & mask_o) == '0);

endmodule

// File: rtl/canmask_bank.sv
module canmask_bank
    import canmask_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int WIDTH  = 32,
    parameter int FIFO_N = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze_i,
    input  logic             mask_en_i,
    input  logic             fifo_en_i,
    input  logic [AW-1:0]    cpu_addr_i,
    input  logic [WIDTH-1:0] cpu_wdata_i,
    input  logic             cpu_wr_i,
    input  logic             cpu_rd_i,
    output logic [WIDTH-1:0] cpu_rdata_o,
    output logic             cpu_err_o,
    input  logic             lk_fifo_i,
    input  logic [AW-1:0]    lk_idx_i,
    input  logic [WIDTH-1:0] lk_rx_id_i,
    input  logic [WIDTH-1:0] lk_filter_id_i,
    output logic [WIDTH-1:0] lk_mask_o,
    output logic             lk_valid_o,
    output logic             lk_hit_o
);

    acc_kind_t        acc_kind;
    acc_ctl_t         acc_ctl;
    logic [WIDTH-1:0] store_rdata;
    logic [WIDTH-1:0] store_ldata;
    logic [AW-1:0]    lk_word_addr;
    logic             rst_unused;

    // Storage is intentionally outside reset; rst_n only feeds the checker
    assign rst_unused = rst_n;

    canmask_access u_access (
        .freeze_i  (freeze_i),
        .mask_en_i (mask_en_i),
        .wr_i      (cpu_wr_i),
        .rd_i      (cpu_rd_i),
        .kind_o    (acc_kind),
        .ctl_o     (acc_ctl)
    );

    canmask_store #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH)
    ) u_store (
        .clk     (clk),
        .wr_en_i (acc_ctl.wr_en),
        .waddr_i (cpu_addr_i),
        .wdata_i (cpu_wdata_i),
        .raddr_i (cpu_addr_i),
        .rdata_o (store_rdata),
        .laddr_i (lk_word_addr),
        .ldata_o (store_ldata)
    );

    canmask_lookup #(
        .DEPTH  (DEPTH),
        .WIDTH  (WIDTH),
        .FIFO_N (FIFO_N)
    ) u_lookup (
        .fifo_en_i   (fifo_en_i),
        .lk_fifo_i   (lk_fifo_i),
        .lk_idx_i    (lk_idx_i),
        .word_i      (store_ldata),
        .rx_id_i     (lk_rx_id_i),
        .flt_id_i    (lk_filter_id_i),
        .word_addr_o (lk_word_addr),
        .mask_o      (lk_mask_o),
        .valid_o     (lk_valid_o),
        .hit_o       (lk_hit_o)
    );

    assign cpu_rdata_o = acc_ctl.rd_en ? store_rdata : '0;
    assign cpu_err_o   = acc_ctl.err && (acc_kind == ACC_FAULT);

endmodule

// File: rtl/canmask_bank_chk.sv
module canmask_bank_chk #(
    parameter int WIDTH = 32,
    parameter int AW    = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             freeze_i,
    input logic             mask_en_i,
    input logic             fifo_en_i,
    input logic             cpu_wr_i,
    input logic             cpu_rd_i,
    input logic [WIDTH-1:0] cpu_rdata_o,
    input logic             cpu_err_o,
    input logic             lk_fifo_i,
    input logic [AW-1:0]    lk_idx_i,
    input logic [WIDTH-1:0] lk_rx_id_i,
    input logic [WIDTH-1:0] lk_filter_id_i,
    input logic [WIDTH-1:0] lk_mask_o,
    input logic             lk_valid_o,
    input logic             lk_hit_o
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_ERR_ONLY_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_err_o |-> ((cpu_wr_i || cpu_rd_i) && !mask_en_i)); // R5

    AST_FAULT_RAISES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_wr_i || cpu_rd_i) && !mask_en_i) |-> (cpu_err_o && cpu_rdata_o == '0)); // R4

    AST_RDATA_ZERO_UNFROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze_i || !cpu_rd_i) |-> (cpu_rdata_o == '0)); // R3

    AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid_o |-> (!lk_hit_o && lk_mask_o == '0)); // R8

    AST_HIT_MATCHES_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid_o |-> (lk_hit_o == (((lk_rx_id_i ^ lk_filter_id_i) & lk_mask_o) == '0))); // R9

    AST_NO_FIFO_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en_i && lk_fifo_i) |-> !lk_valid_o); // R6

    AST_MASK_HELD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(cpu_wr_i && freeze_i && mask_en_i)
         && $stable(lk_idx_i) && $stable(lk_fifo_i) && $stable(fifo_en_i))
        |-> $stable(lk_mask_o)); // R2

endmodule

bind canmask_bank canmask_bank_chk #(
    .WIDTH (WIDTH),
    .AW    (AW)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .freeze_i       (freeze_i),
    .mask_en_i      (mask_en_i),
    .fifo_en_i      (fifo_en_i),
    .cpu_wr_i       (cpu_wr_i),
    .cpu_rd_i       (cpu_rd_i),
    .cpu_rdata_o    (cpu_rdata_o),
    .cpu_err_o      (cpu_err_o),
    .lk_fifo_i      (lk_fifo_i),
    .lk_idx_i       (lk_idx_i),
    .lk_rx_id_i     (lk_rx_id_i),
    .lk_filter_id_i (lk_filter_id_i),
    .lk_mask_o      (lk_mask_o),
    .lk_valid_o     (lk_valid_o),
    .lk_hit_o       (lk_hit_o)
);

// File: tb/test_canmask_bank.sv
module test_canmask_bank;

    localparam int DEPTH  = 64;
    localparam int WIDTH  = 32;
    localparam int FIFO_N = 8;
    localparam int AW     = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             freeze_i = 1'b0;
    logic             mask_en_i = 1'b1;
    logic             fifo_en_i = 1'b0;
    logic [AW-1:0]    cpu_addr_i = '0;
    logic [WIDTH-1:0] cpu_wdata_i = '0;
    logic             cpu_wr_i = 1'b0;
    logic             cpu_rd_i = 1'b0;
    logic [WIDTH-1:0] cpu_rdata_o;
    logic             cpu_err_o;
    logic             lk_fifo_i = 1'b0;
    logic [AW-1:0]    lk_idx_i = '0;
    logic [WIDTH-1:0] lk_rx_id_i = '0;
    logic [WIDTH-1:0] lk_filter_id_i = '0;
    logic [WIDTH-1:0] lk_mask_o;
    logic             lk_valid_o;
    logic             lk_hit_o;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;
    logic [WIDTH-1:0] model [DEPTH];

    always #5 clk = ~clk;

    canmask_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH), .FIFO_N(FIFO_N)) i_canmask_bank (
        .clk(clk), .rst_n(rst_n), .freeze_i(freeze_i), .mask_en_i(mask_en_i),
        .fifo_en_i(fifo_en_i), .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i),
        .cpu_wr_i(cpu_wr_i), .cpu_rd_i(cpu_rd_i), .cpu_rdata_o(cpu_rdata_o),
        .cpu_err_o(cpu_err_o), .lk_fifo_i(lk_fifo_i), .lk_idx_i(lk_idx_i),
        .lk_rx_id_i(lk_rx_id_i), .lk_filter_id_i(lk_filter_id_i),
        .lk_mask_o(lk_mask_o), .lk_valid_o(lk_valid_o), .lk_hit_o(lk_hit_o)
    );

    function automatic logic [WIDTH-1:0] pat(input int a, input int salt);
        return WIDTH'((a + 1) * 32'h9E3779B9) ^ WIDTH'(salt * 32'h01010101);
    endfunction

    task automatic check(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one CPU cycle; outputs sampled before the rising edge
    task automatic cpu_cycle(input logic w, input logic r, input int a, input logic [WIDTH-1:0] d,
                             output logic [WIDTH-1:0] rd, output logic e);
        @(negedge clk);
        cpu_wr_i    = w;
        cpu_rd_i    = r;
        cpu_addr_i  = AW'(a);
        cpu_wdata_i = d;
        #2;
        rd = cpu_rdata_o;
        e  = cpu_err_o;
        @(posedge clk);
        #1;
        cpu_wr_i = 1'b0;
        cpu_rd_i = 1'b0;
    endtask

    initial begin
        logic [WIDTH-1:0] rd;
        logic e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state of outputs with no strobe
        @(negedge clk);
        fifo_en_i = 1'b0; lk_fifo_i = 1'b1;
        #2;
        check("R3 idle rdata", cpu_rdata_o, '0);
        check("R5 idle err", WIDTH'(cpu_err_o), '0);
        check("R6 fifo target invalid when fifo off", WIDTH'(lk_valid_o), '0);
        check("R8 invalid mask zero", lk_mask_o, '0);

        // R1: fill every word in freeze, then read all back
        freeze_i = 1'b1;
        for (int a = 0; a < DEPTH; a++) begin
            model[a] = pat(a, 0);
            cpu_cycle(1'b1, 1'b0, a, model[a], rd, e);
            check("R5 granted write no err", WIDTH'(e), '0);
        end
        for (int a = 0; a < DEPTH; a++) begin
            cpu_cycle(1'b0, 1'b1, a, '0, rd, e);
            check("R1 readback", rd, model[a]);
        end

        // R2/R3: unfrozen writes discarded, unfrozen reads zero
        freeze_i = 1'b0;
        for (int a = 0; a < DEPTH; a++) begin
            cpu_cycle(1'b1, 1'b0, a, ~model[a], rd, e);
            check("R2 unfrozen write no err", WIDTH'(e), '0);
            cpu_cycle(1'b0, 1'b1, a, '0, rd, e);
            check("R3 unfrozen read zero", rd, '0);
        end
        freeze_i = 1'b1;
        for (int a = 0; a < DEPTH; a++) begin
            cpu_cycle(1'b0, 1'b1, a, '0, rd, e);
            check("R2 word unchanged", rd, model[a]);
        end

        // R4: masking disabled faults, frozen or not
        mask_en_i = 1'b0;
        for (int f = 0; f < 2; f++) begin
            freeze_i = f[0];
            for (int a = 0; a < DEPTH; a += 9) begin
                cpu_cycle(1'b1, 1'b0, a, pat(a, 7), rd, e);
                check("R4 write err", WIDTH'(e), 1);
                check("R4 write rdata zero", rd, '0);
                cpu_cycle(1'b0, 1'b1, a, '0, rd, e);
                check("R4 read err", WIDTH'(e), 1);
                check("R4 read rdata zero", rd, '0);
            end
        end
        mask_en_i = 1'b1; freeze_i = 1'b1;
        for (int a = 0; a < DEPTH; a += 9) begin
            cpu_cycle(1'b0, 1'b1, a, '0, rd, e);
            check("R4 faulted write left word", rd, model[a]);
        end

        // R11: read and write together return old data
        cpu_cycle(1'b1, 1'b1, 5, pat(5, 3), rd, e);
        check("R11 read sees old word", rd, model[5]);
        model[5] = pat(5, 3);
        cpu_cycle(1'b0, 1'b1, 5, '0, rd, e);
        check("R11 new word next cycle", rd, model[5]);

        // R12: reset leaves storage alone
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        for (int a = 0; a < DEPTH; a += 7) begin
            cpu_cycle(1'b0, 1'b1, a, '0, rd, e);
            check("R12 word kept over reset", rd, model[a]);
        end

        // R6..R10: lookup sweep with CPU access closed
        freeze_i = 1'b0; mask_en_i = 1'b0;
        for (int fe = 0; fe < 2; fe++) begin
            for (int lf = 0; lf < 2; lf++) begin
                for (int i = 0; i < DEPTH; i++) begin
                    logic v;
                    logic [WIDTH-1:0] m, diff;
                    logic h;
                    if (fe == 1) v = (lf == 1) ? (i < FIFO_N) : (i >= FIFO_N);
                    else         v = (lf == 0);
                    m = v ? model[i] : '0;
                    if (i % 2 == 0) diff = ~model[i];
                    else            diff = model[i] & (~model[i] + 1);
                    h = v && ((diff & m) == '0);
                    @(negedge clk);
                    fifo_en_i = fe[0]; lk_fifo_i = lf[0]; lk_idx_i = AW'(i);
                    lk_filter_id_i = pat(i, 11);
                    lk_rx_id_i = pat(i, 11) ^ diff;
                    #2;
                    if (fe == 1) begin
                        check("R7 valid", WIDTH'(lk_valid_o), WIDTH'(v));
                        check("R7 mask", lk_mask_o, m);
                    end else begin
                        check("R6 valid", WIDTH'(lk_valid_o), WIDTH'(v));
                        check("R6 mask", lk_mask_o, m);
                    end
                    if (v) check("R9 R10 hit", WIDTH'(lk_hit_o), WIDTH'(h));
                    else   check("R8 invalid no hit", WIDTH'(lk_hit_o), '0);
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule